// File: doc/BRIEF.md
# Converter Serial Result Transmitter

This block drives the output side of a sigma-delta converter's serial port. It divides the master clock by two to make a free-running serial clock. For each conversion it sends one 32-bit frame on a single data line. The frame is framed by an active-low sync output that stays low for the whole frame. A normal frame carries the 24-bit sample, then five status bits, then zero padding. The status bits are settling, overrange, power mode and a two-bit decimation code.

Software can arm a register readback by pulsing `rbArm` with a 16-bit register word. The pulse marks the moment the arming write completed. If that moment lies far enough ahead of the next frame's start, the frame carries the register word in place of the result. If it does not, the readback waits one more frame. Once a readback frame has been sent, normal result frames resume. A result strobe that arrives while a frame is on the line is held, so frames never overlap.

Top module: `serial_result_tx`

## Requirements
- R1: `sclk` is 0 while reset is held. After reset it toggles on every master clock edge, so it runs at half the master clock frequency.
- R2: `fsN` is 1 in reset and between frames. Once per frame it goes low for exactly 32 serial clock periods (64 master clocks).
- R3: `sdo` and `fsN` change only on master edges where `sclk` rises, so they are stable at every falling `sclk` edge. Bits go out most significant first, one per serial clock period. `sdo` is 0 outside frames.
- R4: A result frame is the 24-bit sample, then settled, overrange, low-power, code bit 1 and code bit 0, then 3 zero bits. The sample and the status inputs are both captured on the cycle `resultValid` is high.
- R5: The decimation code is set by `decimSel`. A value of 00 (64x) sends code 01, 01 (128x) sends code 10, and 10 or 11 (256x) send code 00.
- R6: A frame carries the readback word if the latest `rbArm` pulse came at least 16 master clocks (8 serial clock periods) before the master edge on which `fsN` falls. The readback frame is the 16-bit word MSB first, followed by 16 zero bits, and the pending result is dropped.
- R7: If `rbArm` comes less than 16 master clocks before a frame starts, that frame carries the result. The readback goes out in the following frame.
- R8: After a readback frame, the readback is cleared, and the next frame is a normal result frame.
- R9: A `resultValid` pulse during a frame is held. Its frame starts after the current one ends, with `fsN` high for at least one serial clock period in between.
- R10: While reset is held, `sdo` is 0 and `fsN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resultValid | input | 1 | One-cycle strobe: a new sample is ready |
| sampleIn | input | 24 | Conversion result, captured with the strobe |
| settledIn | input | 1 | Filter has settled, data valid |
| ovrIn | input | 1 | Input overrange flag |
| lowPwrIn | input | 1 | Low power mode flag |
| decimSel | input | 2 | Decimation ratio: 00 64x, 01 128x, 10/11 256x |
| rbArm | input | 1 | One-cycle pulse: readback armed (write completed) |
| rbWordIn | input | 16 | Register word to read back, captured with `rbArm` |
| sclk | output | 1 | Serial clock, half the master clock |
| sdo | output | 1 | Serial data out |
| fsN | output | 1 | Frame sync, active low |

## Verification
The properties assume that `resultValid` and `rbArm` are single-cycle pulses that are driven between clock edges. They also assume that `rbArm` never lands on the same edge as a frame start that uses a readback. The bench drives every input on the falling master edge and releases each strobe one cycle later. It places readback arming only while the line is idle, at offsets counted from a known serial clock phase seen at the `sclk` port. This makes the lead time to the frame start an exact count, either 14 or 16 master clocks.

// File: rtl/srt_pkg.sv
package srt_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic start;      // load a new frame into the shifter
    logic useRb;      // the frame being started carries the readback word
    logic shift;      // advance the shifter by one bit
    logic capSample;  // capture sample and status
    logic capRb;      // capture readback word
  } txStb_t;

  // Ratio select -> transmitted decimation code
  function automatic logic [1:0] decimCode(input logic [1:0] sel);
    case (sel)
      2'b00:   decimCode = 2'b01;  // 64x
      2'b01:   decimCode = 2'b10;  // 128x
      default: decimCode = 2'b00;  // 256x
    endcase
  endfunction

endpackage

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import srt_pkg::*;
#(
  parameter int FRAME_W   = 32,
  parameter int LEAD_SCLK = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   resultValid,
  input  logic   rbArm,
  output logic   sclk,
  output logic   fsN,
  output txStb_t stb
);

  localparam int CNT_W     = $clog2(FRAME_W);
  localparam int LEAD_CLKS = 2 * LEAD_SCLK;
  localparam int LEAD_W    = $clog2(LEAD_CLKS + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [LEAD_W-1:0] LEAD_MIN = LEAD_W'(LEAD_CLKS);

  logic              sclkQ;
  logic              busyQ;
  logic [CNT_W-1:0]  bitCntQ;
  logic              pendQ;
  logic              armedQ;
  logic [LEAD_W-1:0] leadQ;

  logic launch;
  logic startNow;
  logic rbReady;

  // A launch edge is the master edge on which sclk rises
  assign launch   = ~sclkQ;
  assign rbReady  = armedQ && (leadQ >= LEAD_MIN);
  assign startNow = launch && !busyQ && pendQ;

  always_comb begin
    stb           = '0;
    stb.start     = startNow;
    stb.useRb     = rbReady;
    stb.shift     = launch && busyQ;
    stb.capSample = resultValid;
    stb.capRb     = rbArm;
  end

  // Serial clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= ~sclkQ;
  end

  // Frame sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      bitCntQ <= '0;
    end else if (launch) begin
      if (busyQ) begin
        if (bitCntQ == LAST_BIT) busyQ <= 1'b0;
        else                     bitCntQ <= bitCntQ + 1'b1;
      end else if (pendQ) begin
        busyQ   <= 1'b1;
        bitCntQ <= '0;
      end
    end
  end

  // Held result request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pendQ <= 1'b0;
    else if (resultValid) pendQ <= 1'b1;
    else if (startNow)    pendQ <= 1'b0;
  end

  // Readback arming and lead-time count (value k means armed k edges ago)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      leadQ  <= '0;
    end else if (rbArm) begin
      armedQ <= 1'b1;
      leadQ  <= LEAD_W'(1);
    end else if (startNow && rbReady) begin
      armedQ <= 1'b0;
      leadQ  <= '0;
    end else if (armedQ && leadQ < LEAD_MIN) begin
      leadQ <= leadQ + 1'b1;
    end
  end

  assign sclk = sclkQ;
  assign fsN  = ~busyQ;

endmodule

// File: rtl/srt_datapath.sv
module srt_datapath
  import srt_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RB_W     = 16,
  parameter int FRAME_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStb_t              stb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                settledIn,
  input  logic                ovrIn,
  input  logic                lowPwrIn,
  input  logic [1:0]          decimSel,
  input  logic [RB_W-1:0]     rbWordIn,
  output logic                sdo
);

  localparam int STAT_W = 5;
  localparam int PAD_W  = FRAME_W - SAMPLE_W - STAT_W;

  logic [FRAME_W-1:0] resWordQ;
  logic [RB_W-1:0]    rbQ;
  logic [FRAME_W-1:0] shiftQ;
  logic [FRAME_W-1:0] resWordD;
  logic [FRAME_W-1:0] rbFrame;
  logic [STAT_W-1:0]  statBits;

  assign statBits = {settledIn, ovrIn, lowPwrIn, decimCode(decimSel)};

  generate
    if (PAD_W > 0) begin : g_resPad
      assign resWordD = {sampleIn, statBits, {PAD_W{1'b0}}};
    end else begin : g_resNoPad
      assign resWordD = {sampleIn, statBits};
    end
    if (RB_W < FRAME_W) begin : g_rbPad
      assign rbFrame = {rbQ, {(FRAME_W - RB_W){1'b0}}};
    end else begin : g_rbNoPad
      assign rbFrame = rbQ[RB_W-1 -: FRAME_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resWordQ <= '0;
      rbQ      <= '0;
    end else begin
      if (stb.capSample) resWordQ <= resWordD;
      if (stb.capRb)     rbQ      <= rbWordIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shiftQ <= '0;
    else if (stb.start) shiftQ <= stb.useRb ? rbFrame : resWordQ;
    else if (stb.shift) shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
  end

  assign sdo = shiftQ[FRAME_W-1];

endmodule

// File: rtl/serial_result_tx.sv
module serial_result_tx
  import srt_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int RB_W      = 16,
  parameter int FRAME_W   = 32,
  parameter int LEAD_SCLK = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                resultValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                settledIn,
  input  logic                ovrIn,
  input  logic                lowPwrIn,
  input  logic [1:0]          decimSel,
  input  logic                rbArm,
  input  logic [RB_W-1:0]     rbWordIn,
  output logic                sclk,
  output logic                sdo,
  output logic                fsN
);

  txStb_t ctrlStb;

  srt_ctrl #(
    .FRAME_W  (FRAME_W),
    .LEAD_SCLK(LEAD_SCLK)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resultValid(resultValid),
    .rbArm      (rbArm),
    .sclk       (sclk),
    .fsN        (fsN),
    .stb        (ctrlStb)
  );

  srt_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .RB_W    (RB_W),
    .FRAME_W (FRAME_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctrlStb),
    .sampleIn (sampleIn),
    .settledIn(settledIn),
    .ovrIn    (ovrIn),
    .lowPwrIn (lowPwrIn),
    .decimSel (decimSel),
    .rbWordIn (rbWordIn),
    .sdo      (sdo)
  );

endmodule

// File: rtl/serial_result_tx_chk.sv
module serial_result_tx_chk #(
  parameter int FRAME_W = 32
) (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic sdo,
  input logic fsN,
  input logic rbArm,
  input logic stbStart,
  input logic stbUseRb
);

  localparam int LOW_CLKS = 2 * FRAME_W;
  localparam int CW       = $clog2(LOW_CLKS + 2);

  logic [CW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        lowCnt <= '0;
    else if (fsN)                     lowCnt <= '0;
    else if (lowCnt != {CW{1'b1}})    lowCnt <= lowCnt + 1'b1;
  end

  // R1: serial clock toggles on every master edge after reset
  a_r1_sclk_toggle: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (sclk != $past(sclk)));

  // R2: sync low exactly 64 master clocks per frame
  a_r2_frame_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsN) |-> (lowCnt == CW'(LOW_CLKS)));

  // R3: data changes only with a rising serial clock
  a_r3_sdo_launch: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdo) |-> $rose(sclk));

  // R3: frame sync changes only with a rising serial clock
  a_r3_fs_launch: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fsN) |-> $rose(sclk));

  // R8: a sent readback is no longer offered
  a_r8_rb_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stbStart && stbUseRb && !rbArm) |=> !stbUseRb);

  // R9: sync stays high for at least one serial period between frames
  a_r9_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsN) |=> fsN);

endmodule

bind serial_result_tx serial_result_tx_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclk    (sclk),
  .sdo     (sdo),
  .fsN     (fsN),
  .rbArm   (rbArm),
  .stbStart(ctrlStb.start),
  .stbUseRb(ctrlStb.useRb)
);

// File: tb/serial_result_tx_tb.sv
module serial_result_tx_tb;

  localparam int CLK_P = 10;
  localparam int NV    = 5;

  // {sample[23:0], settled, ovr, lowPwr, decimSel[1:0]}
  localparam logic [28:0] STIM [NV] = '{
    {24'hA5C3F0, 1'b1, 1'b0, 1'b0, 2'b00},
    {24'h000001, 1'b0, 1'b1, 1'b1, 2'b01},
    {24'hFFFFFF, 1'b1, 1'b1, 1'b1, 2'b10},
    {24'h800000, 1'b0, 1'b0, 1'b0, 2'b11},
    {24'h123456, 1'b1, 1'b0, 1'b1, 2'b01}
  };
  localparam logic [31:0] EXPV [NV] = '{
    32'hA5C3F088, 32'h00000170, 32'hFFFFFFE0, 32'h80000000, 32'h123456B0
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [23:0] sampleIn = '0;
  logic        settledIn = 1'b0;
  logic        ovrIn = 1'b0;
  logic        lowPwrIn = 1'b0;
  logic [1:0]  decimSel = 2'b00;
  logic        rbArm = 1'b0;
  logic [15:0] rbWordIn = '0;
  logic        sclk;
  logic        sdo;
  logic        fsN;

  int nChk = 0;
  int nBad = 0;

  always #(CLK_P / 2) clk = ~clk;

  serial_result_tx u_dut (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .sampleIn(sampleIn),
    .settledIn(settledIn), .ovrIn(ovrIn), .lowPwrIn(lowPwrIn),
    .decimSel(decimSel), .rbArm(rbArm), .rbWordIn(rbWordIn),
    .sclk(sclk), .sdo(sdo), .fsN(fsN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; strobe is sampled at the next rising edge
  task automatic pushResult(input logic [28:0] v);
    {sampleIn, settledIn, ovrIn, lowPwrIn, decimSel} = v;
    resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0;
  endtask

  task automatic armRb(input logic [15:0] w);
    rbWordIn = w;
    rbArm    = 1'b1;
    @(negedge clk);
    rbArm    = 1'b0;
  endtask

  // Collect one frame: bits taken while sclk is high inside the low sync
  task automatic getFrame(output logic [31:0] w, output int lowN, output int highN);
    w = '0; lowN = 0; highN = 0;
    while (fsN) begin highN++; @(negedge clk); end
    while (!fsN) begin
      lowN++;
      if (sclk) w = {w[30:0], sdo};
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] w, w2;
    int lowN, highN;

    // Reset state: R1, R10
    repeat (3) @(negedge clk);
    check("R1 sclk in reset", {31'b0, sclk}, 32'd0);
    check("R10 fsN in reset", {31'b0, fsN}, 32'd1);
    check("R10 sdo in reset", {31'b0, sdo}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = sclk;
      @(negedge clk);
      check("R1 sclk toggles", {31'b0, sclk}, {31'b0, ~prev});
    end
    check("R2 fsN idle high", {31'b0, fsN}, 32'd1);

    // Vector table: R4, R5, R2, R3
    for (int i = 0; i < NV; i++) begin
      pushResult(STIM[i]);
      getFrame(w, lowN, highN);
      check($sformatf("R4 R5 frame %0d", i), w, EXPV[i]);
      check("R2 sync low width", lowN, 32'd64);
      check("R3 sdo zero after frame", {31'b0, sdo}, 32'd0);
    end

    // R9: result strobe during a frame is held
    pushResult(STIM[0]);
    fork
      getFrame(w, lowN, highN);
      begin
        repeat (20) @(negedge clk);
        pushResult(STIM[2]);
      end
    join
    getFrame(w2, lowN, highN);
    check("R9 first frame intact", w, EXPV[0]);
    check("R9 held frame sent", w2, EXPV[2]);
    check("R9 gap at least one sclk", {31'b0, highN >= 2}, 32'd1);

    // R7: arm 14 master clocks before start -> result frame, readback next
    repeat (4) @(negedge clk);
    while (sclk) @(negedge clk);
    armRb(16'hBEEF);
    repeat (12) @(negedge clk);
    pushResult(STIM[1]);
    getFrame(w, lowN, highN);
    check("R7 late arm gives result", w, EXPV[1]);
    pushResult(STIM[3]);
    getFrame(w, lowN, highN);
    check("R7 readback in following frame", w, 32'hBEEF0000);

    // R8: next frame is a normal result
    pushResult(STIM[4]);
    getFrame(w, lowN, highN);
    check("R8 result after readback", w, EXPV[4]);

    // R6: arm exactly 16 master clocks before start -> readback
    repeat (4) @(negedge clk);
    while (sclk) @(negedge clk);
    armRb(16'h1357);
    repeat (13) @(negedge clk);
    pushResult(STIM[0]);
    getFrame(w, lowN, highN);
    check("R6 lead of 16 gives readback", w, 32'h13570000);
    check("R6 readback frame width", lowN, 32'd64);
    pushResult(STIM[2]);
    getFrame(w, lowN, highN);
    check("R8 cleared after readback", w, EXPV[2]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule